// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column command into the stream of column addresses a synchronous DRAM steps through during a burst. The controller presents a start column, a burst length code and a wrap order together with a column command strobe. From the next clock on, the block gives out one column per cycle, a valid strobe, and a flag on the final beat.

Two wrap orders are available. In sequential order the low bits count upward and wrap inside the aligned burst window. In interleaved order the low bits are the start bits XORed with the beat number. A whole-row mode walks every column of the 256-column row and keeps going until the controller ends it.

A burst can be ended early by a stop strobe, which stands for a burst-stop or a precharge command. A new column command may arrive on any cycle. It discards the running burst and restarts from the new start column with the new settings. Data alignment for CAS latency is handled elsewhere.

Top module: `burst_colgen`

## Requirements
- R1: After reset, col_valid and col_last are 0 and col_out is 0.
- R2: When cmd_start is 1 at a clock edge, the next cycle shows col_valid=1 and col_out equal to the start_col sampled at that edge (beat 0).
- R3: bl_code values 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. After the last beat, col_valid returns to 0 on the next cycle unless a new command arrives.
- R4: With wrap_ilv=0 and a fixed length BL, beat k outputs the column whose low log2(BL) bits are (start low bits + k) mod BL, with the upper bits equal to those of the start column.
- R5: With wrap_ilv=1 and a fixed length BL, beat k outputs the column whose low log2(BL) bits are (start low bits XOR k), with the upper bits unchanged.
- R6: Any bl_code with bit 2 set selects whole-row mode. The column increments by one modulo 256 every beat, wrap_ilv is ignored, and the burst runs on past 256 beats until it is ended.
- R7: col_last is 1 exactly on the final beat of a fixed-length burst and is never 1 in whole-row mode.
- R8: cmd_stop=1 without cmd_start at an edge ends the burst, so col_valid is 0 on the next cycle.
- R9: cmd_start on any cycle, including during a running burst or together with cmd_stop, restarts the burst from the new start_col with the new bl_code and wrap_ilv.
- R10: start_col, bl_code and wrap_ilv are sampled only at a column command. Changing them during a burst does not alter the remaining columns.
- R11: col_out reads 0 in every cycle in which col_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | Column command (read or write) strobe |
| cmd_stop | input | 1 | Burst-stop or precharge strobe |
| start_col | input | 8 | Start column of the burst |
| bl_code | input | 3 | Burst length: 0..3 give 1,2,4,8 beats; bit 2 set selects whole row |
| wrap_ilv | input | 1 | 0 selects sequential order, 1 selects interleaved order |
| col_out | output | 8 | Current column, 0 while idle |
| col_valid | output | 1 | Column on col_out is a live beat |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench starts bursts whose start column sits in the middle of the burst window. A design that forgets to keep the upper bits fixed would step across the window boundary instead of wrapping back. It runs sequential and interleaved bursts from the same starts, so mixing up the two orders shows up in the second beat. A whole-row burst is started at column 254 and run past 256 beats: a design that applies the interleave setting, raises the last flag, or stops at a fixed count fails there. Further cases are commands on consecutive cycles, a command coinciding with a stop, a stop in mid-burst, and mode inputs changed during a burst. These catch a design that lets the stop win, resumes the old beat count, or reads the mode inputs live.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int BL_SEL_W = 3;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

  // Window mask for a fixed burst: 2**code - 1
  function automatic int unsigned window_mask(input logic [1:0] code);
    return (32'd1 << code) - 32'd1;
  endfunction
endpackage

// File: rtl/colgen_len_dec.sv
module colgen_len_dec #(
  parameter int COL_W = 8
) (
  input  logic [colgen_pkg::BL_SEL_W-1:0] bl_code,
  output logic                            whole_row,
  output logic [COL_W-1:0]                win_mask
);
  always_comb begin
    whole_row = bl_code[2];
    win_mask  = COL_W'(colgen_pkg::window_mask(bl_code[1:0]));
  end
endmodule

// File: rtl/colgen_seq.sv
module colgen_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             halt,
  input  logic [COL_W-1:0] start_in,
  input  logic [COL_W-1:0] mask_in,
  input  logic             whole_in,
  input  logic             ilv_in,
  output logic             active,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] start_q,
  output logic [COL_W-1:0] mask_q,
  output logic             whole_q,
  output logic             ilv_q,
  output logic             final_beat
);
  logic             active_r;
  logic [COL_W-1:0] beat_r;

  assign final_beat = active_r & ~whole_q & (beat_r == mask_q);
  assign active     = active_r;
  assign beat       = beat_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_r <= 1'b0;
      beat_r   <= '0;
      start_q  <= '0;
      mask_q   <= '0;
      whole_q  <= 1'b0;
      ilv_q    <= 1'b0;
    end else if (go) begin
      active_r <= 1'b1;
      beat_r   <= '0;
      start_q  <= start_in;
      mask_q   <= mask_in;
      whole_q  <= whole_in;
      ilv_q    <= ilv_in;
    end else if (halt) begin
      active_r <= 1'b0;
    end else if (active_r) begin
      if (final_beat) active_r <= 1'b0;
      else            beat_r   <= beat_r + 1'b1;
    end
  end
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             whole,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  import colgen_pkg::*;

  function automatic logic [COL_W-1:0] seq_col(
    input logic [COL_W-1:0] s, input logic [COL_W-1:0] k, input logic [COL_W-1:0] m);
    return (s & ~m) | ((s + k) & m);
  endfunction

  function automatic logic [COL_W-1:0] ilv_col(
    input logic [COL_W-1:0] s, input logic [COL_W-1:0] k, input logic [COL_W-1:0] m);
    return (s & ~m) | ((s ^ k) & m);
  endfunction

  always_comb begin
    if (whole)                      col = start_col + beat;
    else if (order_e'(ilv) == ORD_ILV) col = ilv_col(start_col, beat, mask);
    else                            col = seq_col(start_col, beat, mask);
  end
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen #(
  parameter int COL_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cmd_start,
  input  logic                            cmd_stop,
  input  logic [COL_W-1:0]                start_col,
  input  logic [colgen_pkg::BL_SEL_W-1:0] bl_code,
  input  logic                            wrap_ilv,
  output logic [COL_W-1:0]                col_out,
  output logic                            col_valid,
  output logic                            col_last
);
  // Named internal events for the checker
  logic             evt_load, evt_halt, evt_final;
  logic             dec_whole;
  logic [COL_W-1:0] dec_mask;
  logic             run_active, mode_full_w, mode_ilv_w;
  logic [COL_W-1:0] run_beat, run_start, mode_mask_w, addr_col;

  assign evt_load = cmd_start;
  assign evt_halt = cmd_stop & ~cmd_start;

  colgen_len_dec #(.COL_W(COL_W)) u_dec (
    .bl_code  (bl_code),
    .whole_row(dec_whole),
    .win_mask (dec_mask)
  );

  colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (evt_load),
    .halt      (evt_halt),
    .start_in  (start_col),
    .mask_in   (dec_mask),
    .whole_in  (dec_whole),
    .ilv_in    (wrap_ilv),
    .active    (run_active),
    .beat      (run_beat),
    .start_q   (run_start),
    .mask_q    (mode_mask_w),
    .whole_q   (mode_full_w),
    .ilv_q     (mode_ilv_w),
    .final_beat(evt_final)
  );

  colgen_addr #(.COL_W(COL_W)) u_addr (
    .start_col(run_start),
    .beat     (run_beat),
    .mask     (mode_mask_w),
    .whole    (mode_full_w),
    .ilv      (mode_ilv_w),
    .col      (addr_col)
  );

  assign col_valid = run_active;
  assign col_out   = run_active ? addr_col : '0;
  assign col_last  = evt_final;
endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_load,
  input logic             evt_halt,
  input logic             evt_final,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             col_last,
  input logic             mode_full_w,
  input logic [COL_W-1:0] mode_mask_w
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_load |=> col_valid && col_out == $past(start_col));

  assert_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_final && !evt_load |=> !col_valid);

  assert_run_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_last && !evt_load && !evt_halt |=> col_valid);

  assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !mode_full_w && !col_last && !evt_load && !evt_halt
    |=> (col_out & ~mode_mask_w) == ($past(col_out) & ~$past(mode_mask_w)));

  assert_row_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && mode_full_w && !evt_load && !evt_halt
    |=> col_valid && col_out == COL_W'($past(col_out) + 1'b1));

  assert_no_last_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && mode_full_w |-> !col_last);

  assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_halt |=> !col_valid);
endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_load   (evt_load),
  .evt_halt   (evt_halt),
  .evt_final  (evt_final),
  .start_col  (start_col),
  .col_out    (col_out),
  .col_valid  (col_valid),
  .col_last   (col_last),
  .mode_full_w(mode_full_w),
  .mode_mask_w(mode_mask_w)
);

// File: tb/burst_colgen_test.sv
module burst_colgen_test;
  localparam int CLK_T = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_start = 1'b0, cmd_stop = 1'b0, wrap_ilv = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] bl_code = '0;
  logic [7:0] col_out;
  logic       col_valid, col_last;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    int         at;
    logic       v;
    logic [7:0] col;
    logic       last;
    string      tag;
  } item_t;
  item_t sb[$];

  // reference model state
  bit m_act = 0, m_ilv = 0, m_full = 0;
  int m_start = 0, m_beat = 0, m_len = 1;

  burst_colgen uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .start_col(start_col), .bl_code(bl_code), .wrap_ilv(wrap_ilv),
    .col_out(col_out), .col_valid(col_valid), .col_last(col_last));

  always #(CLK_T/2) clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  function automatic int ref_col(int s, int k, int len, bit ilv, bit full);
    int lo, base;
    if (full) return (s + k) % 256;
    lo = s % len;
    base = s - lo;
    if (ilv) return base + (lo ^ k);
    return base + ((lo + k) % len);
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // driver: drive one cycle and push the expected post-edge result
  task automatic step(input bit go, input bit halt, input int col, input int code,
                      input bit ilv, input string tag);
    item_t it;
    @(posedge clk); #1;
    cmd_start = go; cmd_stop = halt; start_col = col[7:0];
    bl_code = code[2:0]; wrap_ilv = ilv;
    if (go) begin
      m_act = 1; m_start = col; m_beat = 0; m_ilv = ilv;
      m_full = (code >= 4); m_len = m_full ? 256 : (1 << code);
    end else if (halt) begin
      m_act = 0;
    end else if (m_act) begin
      if (!m_full && m_beat == m_len - 1) m_act = 0;
      else m_beat = (m_beat + 1) % 256;
    end
    it.at = cyc + 1;
    it.v = m_act;
    it.col = m_act ? 8'(ref_col(m_start, m_beat, m_len, m_ilv, m_full)) : 8'h00;
    it.last = m_act && !m_full && (m_beat == m_len - 1);
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  // monitor: compare at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0 && sb[0].at == cyc) begin
        item_t e;
        e = sb.pop_front();
        checks++;
        if (col_valid !== e.v || col_out !== e.col || col_last !== e.last) begin
          errors++;
          $display("FAIL %s cyc=%0d: got v=%0b col=%02h last=%0b, exp v=%0b col=%02h last=%0b",
                   e.tag, cyc, col_valid, col_out, col_last, e.v, e.col, e.last);
        end
      end
    end
  end

  initial begin
    #(CLK_T * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (col_valid !== 1'b0 || col_last !== 1'b0 || col_out !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset: got v=%0b last=%0b col=%02h, exp 0 0 00",
               col_valid, col_last, col_out);
    end
    rst_n = 1'b1;
    idle(2, "R1/R11 idle");

    step(1, 0, 'h37, 0, 0, "R2/R3 BL1");          idle(2, "R3 BL1 end");
    step(1, 0, 'h36, 1, 0, "R3/R4 BL2");          idle(3, "R4 BL2");
    step(1, 0, 'h36, 2, 0, "R4 BL4 seq");         idle(5, "R4 BL4 seq");
    step(1, 0, 'h7D, 3, 0, "R4/R7 BL8 seq");      idle(9, "R4/R7 BL8 seq");
    step(1, 0, 'h7D, 3, 1, "R5/R7 BL8 ilv");      idle(9, "R5/R7 BL8 ilv");
    step(1, 0, 'hA2, 2, 1, "R5 BL4 ilv");         idle(5, "R5 BL4 ilv");
    step(1, 0, 'h03, 1, 1, "R5 BL2 ilv");         idle(3, "R5 BL2 ilv");

    step(1, 0, 'hFE, 7, 1, "R6/R7 row");          idle(262, "R6/R7 row run");
    step(0, 1, 0, 0, 0, "R8 row stop");           idle(3, "R8/R11 after stop");
    step(1, 0, 'h10, 4, 0, "R6 code4 row");       idle(5, "R6 code4 row");
    step(0, 1, 0, 0, 0, "R8 code4 stop");         idle(2, "R8 idle");

    step(1, 0, 'h58, 3, 0, "R8 BL8");             idle(2, "R8 BL8");
    step(0, 1, 0, 0, 0, "R8 mid stop");           idle(3, "R8/R11 after stop");

    step(1, 0, 'h20, 3, 0, "R9 first");           idle(2, "R9 first");
    step(1, 0, 'h45, 2, 1, "R9 restart");         idle(5, "R9 restart");
    step(1, 0, 'h11, 0, 0, "R9 b2b a");
    step(1, 0, 'h22, 1, 1, "R9 b2b b");
    step(1, 0, 'h33, 2, 0, "R9 b2b c");           idle(5, "R9 b2b tail");
    step(1, 1, 'h6C, 2, 0, "R9 start+stop");      idle(5, "R9 start+stop");

    step(1, 0, 'h94, 3, 0, "R10 launch");
    step(0, 0, 'hFF, 7, 1, "R10 mode change");
    step(0, 0, 'h01, 0, 1, "R10 mode change");
    idle(8, "R10 tail");
    idle(3, "R11 idle");

    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule